// File: doc/BRIEF.md
# Interrupt Presentation Controller

This block sits in front of one processor and presents external and inter-processor interrupts to it. It holds the processor's current priority threshold, a software-set inter-processor request priority, one pending interrupt number with its priority, and a flag that remembers that some offer had to be refused. Numerically lower priority values are more favored. Number 0 means that nothing is pending, and number 2 is reserved for the inter-processor interrupt.

An interrupt source controller offers interrupts one at a time. The presenter accepts an offer only when the offer beats the threshold, the inter-processor request and the interrupt already pending. On acceptance it hands back any interrupt it displaced so that the source can redeliver it. When it refuses an offer, it records that a resend is owed. The processor drives four commands: accept (read the pending word), set threshold, set inter-processor request, and end-of-interrupt. These commands raise or clear pending state. They emit resend requests towards the sources and forward end-of-interrupt notices for real sources. A single level output tells the processor that an interrupt is waiting.

Top module: `irq_presenter`

## Requirements
- R1: After reset the threshold is 0x00, the inter-processor request priority is 0xFF, the pending priority is 0xFF and the pending number is 0. irq_out is low, and an accept returns 0x00000000.
- R2: irq_out is high exactly when the pending number is nonzero and the pending priority is numerically below the threshold.
- R3: An offer of priority p is accepted (offer_rsp_ok=1) only if the threshold, the inter-processor request priority and the pending priority are all numerically above p. On acceptance the offered number and p become pending, and the displaced number is reported on reject_num.
- R4: A refused offer (offer_rsp_ok=0) sets the owed-resend flag. The next operation that drains the flag raises resend_req.
- R5: Command op 0 (accept) returns cmd_rsp_xirr = {threshold[7:0], pending number[23:0]}. If a number was pending, the threshold takes the pending priority, the pending priority becomes 0xFF and the number clears. Otherwise the state is unchanged.
- R6: Command op 2 (set request, value in cmd_data[7:0]) stores the new request priority. If it is below the threshold and not above the pending priority, the pending number is displaced, the value becomes the pending priority and number 2 becomes pending.
- R7: When op 2 makes the request priority numerically larger than before, the owed-resend flag is emitted on resend_req and cleared.
- R8: Command op 1 (set threshold, value in cmd_data[7:0]) with an equal value has no effect. With a smaller value, the value is stored, and if it is not above the pending priority, the pending number is displaced and cleared and the pending priority becomes 0xFF.
- R9: Op 1 with a larger value lowers the threshold: the value is stored, number 2 becomes pending if the request priority is below the new threshold and not above the pending priority, and the owed-resend flag is emitted on resend_req and cleared.
- R10: Command op 3 (end-of-interrupt) lowers the threshold as in R9 using cmd_data[31:24]. It forwards cmd_data[23:0] on eoi_num with eoi_valid unless that number is 2.
- R11: A displaced number equal to 2 or 0 never raises reject_valid.
- R12: A command and an offer in the same cycle: the command is served, offer_ready is low, and no offer response follows; the held offer is served in a later cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Processor command present this cycle |
| cmd_op | input | 2 | 0 accept, 1 set threshold, 2 set request, 3 end-of-interrupt |
| cmd_data | input | 32 | Command operand |
| cmd_rsp_valid | output | 1 | Accept result valid |
| cmd_rsp_xirr | output | 32 | Threshold and pending number returned by accept |
| offer_valid | input | 1 | Source offers an interrupt |
| offer_num | input | 24 | Offered interrupt number |
| offer_pri | input | 8 | Offered priority |
| offer_ready | output | 1 | Offer is taken this cycle |
| offer_rsp_valid | output | 1 | Offer verdict valid |
| offer_rsp_ok | output | 1 | Offer accepted (1) or refused (0) |
| reject_valid | output | 1 | A displaced number must be redelivered |
| reject_num | output | 24 | Displaced number |
| resend_req | output | 1 | Sources should retry refused offers |
| eoi_valid | output | 1 | End-of-interrupt forwarded to the source |
| eoi_num | output | 24 | Number being completed |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
A reference model in the bench drives offers that beat every gate, offers that tie the pending priority, and offers blocked by the threshold at reset. These tell the strict "above p" comparison apart from a non-strict one and show whether a refusal is remembered. Request-priority writes go both down and up, and threshold writes go up, down and to the same value. These separate injection from displacement and resend draining, and they show that a no-change write leaves the state alone. End-of-interrupt is issued for the reserved number and for a real one, and a command collides with a held offer to expose the arbitration order.

// File: rtl/ipr_pkg.sv
package ipr_pkg;
  typedef enum logic [1:0] {
    OP_ACCEPT   = 2'd0,
    OP_SET_CPPR = 2'd1,
    OP_SET_MFRR = 2'd2,
    OP_EOI      = 2'd3
  } op_e;

  localparam int IPI_ID = 2;
endpackage

// File: rtl/ipr_rst_sync.sv
module ipr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      meta_q     <= 1'b1;
      rst_sync_n <= meta_q;
    end
  end
endmodule

// File: rtl/ipr_arbiter.sv
module ipr_arbiter (
  input  logic cmd_valid,
  input  logic offer_valid,
  output logic cmd_go,
  output logic off_go,
  output logic offer_ready
);
  always_comb begin
    cmd_go      = cmd_valid;
    off_go      = offer_valid && !cmd_valid;
    offer_ready = !cmd_valid;
  end
endmodule

// File: rtl/ipr_next.sv
module ipr_next #(
  parameter int NUM_W = 24,
  parameter int PRI_W = 8,
  localparam int CMD_W = NUM_W + PRI_W
) (
  input  logic             cmd_go,
  input  logic [1:0]       cmd_op,
  input  logic [CMD_W-1:0] cmd_data,
  input  logic             off_go,
  input  logic [NUM_W-1:0] off_num,
  input  logic [PRI_W-1:0] off_pri,
  input  logic [PRI_W-1:0] cppr_q,
  input  logic [PRI_W-1:0] mfrr_q,
  input  logic [PRI_W-1:0] pend_q,
  input  logic [NUM_W-1:0] xisr_q,
  input  logic             nres_q,
  output logic [PRI_W-1:0] cppr_d,
  output logic [PRI_W-1:0] mfrr_d,
  output logic [PRI_W-1:0] pend_d,
  output logic [NUM_W-1:0] xisr_d,
  output logic             nres_d,
  output logic             rsp_v_d,
  output logic [CMD_W-1:0] rsp_xirr_d,
  output logic             rej_v_d,
  output logic [NUM_W-1:0] rej_num_d,
  output logic             resend_d,
  output logic             eoi_v_d,
  output logic [NUM_W-1:0] eoi_num_d,
  output logic             orsp_v_d,
  output logic             orsp_ok_d
);
  import ipr_pkg::*;

  localparam logic [NUM_W-1:0] IPI_NUM  = NUM_W'(IPI_ID);
  localparam logic [PRI_W-1:0] PRI_NONE = '1;

  op_e              op;
  logic [PRI_W-1:0] cmd_lo;
  logic [PRI_W-1:0] eoi_pri;
  logic [NUM_W-1:0] eoi_src;
  logic [PRI_W-1:0] down_val;
  logic             do_down;
  logic             ipi_on_down;
  logic             ipi_on_mfrr;
  logic             offer_wins;
  logic [NUM_W-1:0] displaced;

  always_comb begin
    op          = op_e'(cmd_op);
    cmd_lo      = cmd_data[PRI_W-1:0];
    eoi_pri     = cmd_data[CMD_W-1 -: PRI_W];
    eoi_src     = cmd_data[NUM_W-1:0];
    down_val    = (op == OP_EOI) ? eoi_pri : cmd_lo;
    do_down     = cmd_go && ((op == OP_EOI) ||
                             ((op == OP_SET_CPPR) && (cmd_lo > cppr_q)));
    ipi_on_down = (mfrr_q < down_val) && (mfrr_q <= pend_q);
    ipi_on_mfrr = (cmd_lo < cppr_q) && (cmd_lo <= pend_q);
    offer_wins  = (cppr_q > off_pri) && (mfrr_q > off_pri) && (pend_q > off_pri);
  end

  always_comb begin
    cppr_d     = cppr_q;
    mfrr_d     = mfrr_q;
    pend_d     = pend_q;
    xisr_d     = xisr_q;
    nres_d     = nres_q;
    rsp_v_d    = 1'b0;
    rsp_xirr_d = '0;
    resend_d   = 1'b0;
    eoi_v_d    = 1'b0;
    eoi_num_d  = '0;
    orsp_v_d   = 1'b0;
    orsp_ok_d  = 1'b0;
    displaced  = '0;

    if (do_down) begin
      cppr_d   = down_val;
      resend_d = nres_q;
      nres_d   = 1'b0;
      if (ipi_on_down) begin
        pend_d = mfrr_q;
        xisr_d = IPI_NUM;
      end
      if ((op == OP_EOI) && (eoi_src != IPI_NUM)) begin
        eoi_v_d   = 1'b1;
        eoi_num_d = eoi_src;
      end
    end else if (cmd_go) begin
      unique case (op)
        OP_ACCEPT: begin
          rsp_v_d    = 1'b1;
          rsp_xirr_d = {cppr_q, xisr_q};
          if (xisr_q != '0) begin
            cppr_d = pend_q;
            pend_d = PRI_NONE;
            xisr_d = '0;
          end
        end
        OP_SET_CPPR: begin
          if (cmd_lo < cppr_q) begin
            cppr_d = cmd_lo;
            if (cmd_lo <= pend_q) begin
              displaced = xisr_q;
              xisr_d    = '0;
              pend_d    = PRI_NONE;
            end
          end
        end
        OP_SET_MFRR: begin
          mfrr_d = cmd_lo;
          if (ipi_on_mfrr) begin
            displaced = xisr_q;
            pend_d    = cmd_lo;
            xisr_d    = IPI_NUM;
          end
          if (cmd_lo > mfrr_q) begin
            resend_d = nres_q;
            nres_d   = 1'b0;
          end
        end
        default: begin
        end
      endcase
    end else if (off_go) begin
      orsp_v_d = 1'b1;
      if (offer_wins) begin
        orsp_ok_d = 1'b1;
        displaced = xisr_q;
        xisr_d    = off_num;
        pend_d    = off_pri;
      end else begin
        nres_d = 1'b1;
      end
    end

    rej_v_d   = (displaced != '0) && (displaced != IPI_NUM);
    rej_num_d = rej_v_d ? displaced : '0;
  end
endmodule

// File: rtl/ipr_state.sv
module ipr_state #(
  parameter int NUM_W = 24,
  parameter int PRI_W = 8,
  localparam int CMD_W = NUM_W + PRI_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_en,
  input  logic [PRI_W-1:0] cppr_d,
  input  logic [PRI_W-1:0] mfrr_d,
  input  logic [PRI_W-1:0] pend_d,
  input  logic [NUM_W-1:0] xisr_d,
  input  logic             nres_d,
  input  logic             rsp_v_d,
  input  logic [CMD_W-1:0] rsp_xirr_d,
  input  logic             rej_v_d,
  input  logic [NUM_W-1:0] rej_num_d,
  input  logic             resend_d,
  input  logic             eoi_v_d,
  input  logic [NUM_W-1:0] eoi_num_d,
  input  logic             orsp_v_d,
  input  logic             orsp_ok_d,
  output logic [PRI_W-1:0] cppr_q,
  output logic [PRI_W-1:0] mfrr_q,
  output logic [PRI_W-1:0] pend_q,
  output logic [NUM_W-1:0] xisr_q,
  output logic             nres_q,
  output logic             rsp_v_q,
  output logic [CMD_W-1:0] rsp_xirr_q,
  output logic             rej_v_q,
  output logic [NUM_W-1:0] rej_num_q,
  output logic             resend_q,
  output logic             eoi_v_q,
  output logic [NUM_W-1:0] eoi_num_q,
  output logic             orsp_v_q,
  output logic             orsp_ok_q
);
  // presenter state, written only on a granted command or offer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cppr_q <= '0;
      mfrr_q <= '1;
      pend_q <= '1;
      xisr_q <= '0;
      nres_q <= 1'b0;
    end else if (upd_en) begin
      cppr_q <= cppr_d;
      mfrr_q <= mfrr_d;
      pend_q <= pend_d;
      xisr_q <= xisr_d;
      nres_q <= nres_d;
    end
  end

  // one-cycle event outputs
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_v_q    <= 1'b0;
      rsp_xirr_q <= '0;
      rej_v_q    <= 1'b0;
      rej_num_q  <= '0;
      resend_q   <= 1'b0;
      eoi_v_q    <= 1'b0;
      eoi_num_q  <= '0;
      orsp_v_q   <= 1'b0;
      orsp_ok_q  <= 1'b0;
    end else begin
      rsp_v_q    <= rsp_v_d;
      rsp_xirr_q <= rsp_xirr_d;
      rej_v_q    <= rej_v_d;
      rej_num_q  <= rej_num_d;
      resend_q   <= resend_d;
      eoi_v_q    <= eoi_v_d;
      eoi_num_q  <= eoi_num_d;
      orsp_v_q   <= orsp_v_d;
      orsp_ok_q  <= orsp_ok_d;
    end
  end
endmodule

// File: rtl/irq_presenter.sv
module irq_presenter #(
  parameter int NUM_W = 24,
  parameter int PRI_W = 8,
  localparam int CMD_W = NUM_W + PRI_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic [CMD_W-1:0] cmd_data,
  output logic             cmd_rsp_valid,
  output logic [CMD_W-1:0] cmd_rsp_xirr,
  input  logic             offer_valid,
  input  logic [NUM_W-1:0] offer_num,
  input  logic [PRI_W-1:0] offer_pri,
  output logic             offer_ready,
  output logic             offer_rsp_valid,
  output logic             offer_rsp_ok,
  output logic             reject_valid,
  output logic [NUM_W-1:0] reject_num,
  output logic             resend_req,
  output logic             eoi_valid,
  output logic [NUM_W-1:0] eoi_num,
  output logic             irq_out
);
  logic             rst_sync_n;
  logic             cmd_go, off_go;
  logic [PRI_W-1:0] cppr_q, mfrr_q, pend_q;
  logic [NUM_W-1:0] xisr_q;
  logic             nres_q;
  logic [PRI_W-1:0] cppr_d, mfrr_d, pend_d;
  logic [NUM_W-1:0] xisr_d;
  logic             nres_d;
  logic             rsp_v_d, rej_v_d, resend_d, eoi_v_d, orsp_v_d, orsp_ok_d;
  logic [CMD_W-1:0] rsp_xirr_d;
  logic [NUM_W-1:0] rej_num_d, eoi_num_d;

  ipr_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ipr_arbiter u_arb (
    .cmd_valid   (cmd_valid),
    .offer_valid (offer_valid),
    .cmd_go      (cmd_go),
    .off_go      (off_go),
    .offer_ready (offer_ready)
  );

  ipr_next #(.NUM_W(NUM_W), .PRI_W(PRI_W)) u_next (
    .cmd_go     (cmd_go),
    .cmd_op     (cmd_op),
    .cmd_data   (cmd_data),
    .off_go     (off_go),
    .off_num    (offer_num),
    .off_pri    (offer_pri),
    .cppr_q     (cppr_q),
    .mfrr_q     (mfrr_q),
    .pend_q     (pend_q),
    .xisr_q     (xisr_q),
    .nres_q     (nres_q),
    .cppr_d     (cppr_d),
    .mfrr_d     (mfrr_d),
    .pend_d     (pend_d),
    .xisr_d     (xisr_d),
    .nres_d     (nres_d),
    .rsp_v_d    (rsp_v_d),
    .rsp_xirr_d (rsp_xirr_d),
    .rej_v_d    (rej_v_d),
    .rej_num_d  (rej_num_d),
    .resend_d   (resend_d),
    .eoi_v_d    (eoi_v_d),
    .eoi_num_d  (eoi_num_d),
    .orsp_v_d   (orsp_v_d),
    .orsp_ok_d  (orsp_ok_d)
  );

  ipr_state #(.NUM_W(NUM_W), .PRI_W(PRI_W)) u_state (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .upd_en     (cmd_go || off_go),
    .cppr_d     (cppr_d),
    .mfrr_d     (mfrr_d),
    .pend_d     (pend_d),
    .xisr_d     (xisr_d),
    .nres_d     (nres_d),
    .rsp_v_d    (rsp_v_d),
    .rsp_xirr_d (rsp_xirr_d),
    .rej_v_d    (rej_v_d),
    .rej_num_d  (rej_num_d),
    .resend_d   (resend_d),
    .eoi_v_d    (eoi_v_d),
    .eoi_num_d  (eoi_num_d),
    .orsp_v_d   (orsp_v_d),
    .orsp_ok_d  (orsp_ok_d),
    .cppr_q     (cppr_q),
    .mfrr_q     (mfrr_q),
    .pend_q     (pend_q),
    .xisr_q     (xisr_q),
    .nres_q     (nres_q),
    .rsp_v_q    (cmd_rsp_valid),
    .rsp_xirr_q (cmd_rsp_xirr),
    .rej_v_q    (reject_valid),
    .rej_num_q  (reject_num),
    .resend_q   (resend_req),
    .eoi_v_q    (eoi_valid),
    .eoi_num_q  (eoi_num),
    .orsp_v_q   (offer_rsp_valid),
    .orsp_ok_q  (offer_rsp_ok)
  );

  always_comb begin
    irq_out = (xisr_q != '0) && (pend_q < cppr_q);
  end
endmodule

// File: rtl/ipr_checker.sv
module ipr_checker #(
  parameter int NUM_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic [1:0]       cmd_op,
  input logic             offer_valid,
  input logic             cmd_rsp_valid,
  input logic             offer_rsp_valid,
  input logic             reject_valid,
  input logic [NUM_W-1:0] reject_num,
  input logic             eoi_valid,
  input logic [NUM_W-1:0] eoi_num,
  input logic             irq_out
);
  localparam logic [NUM_W-1:0] IPI_NUM = NUM_W'(ipr_pkg::IPI_ID);

  // R11
  rej_not_ipi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reject_valid |-> (reject_num != IPI_NUM) && (reject_num != '0));

  // R10
  eoi_not_ipi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_valid |-> (eoi_num != IPI_NUM));

  // R12
  cmd_blocks_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !offer_rsp_valid);

  // R12
  offer_served_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (offer_valid && !cmd_valid) |=> offer_rsp_valid);

  // R5
  accept_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'd0) |=> cmd_rsp_valid);

  // R5
  accept_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'd0) |=> !irq_out);
endmodule

bind irq_presenter ipr_checker #(.NUM_W(NUM_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_sync_n),
  .cmd_valid       (cmd_valid),
  .cmd_op          (cmd_op),
  .offer_valid     (offer_valid),
  .cmd_rsp_valid   (cmd_rsp_valid),
  .offer_rsp_valid (offer_rsp_valid),
  .reject_valid    (reject_valid),
  .reject_num      (reject_num),
  .eoi_valid       (eoi_valid),
  .eoi_num         (eoi_num),
  .irq_out         (irq_out)
);

// File: tb/tb_irq_presenter.sv
module tb_irq_presenter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = 2'd0;
  logic [31:0] cmd_data = '0;
  logic        offer_valid = 1'b0;
  logic [23:0] offer_num = '0;
  logic [7:0]  offer_pri = '0;
  logic        cmd_rsp_valid, offer_ready, offer_rsp_valid, offer_rsp_ok;
  logic [31:0] cmd_rsp_xirr;
  logic        reject_valid, resend_req, eoi_valid, irq_out;
  logic [23:0] reject_num, eoi_num;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irq_presenter dut (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data),
    .cmd_rsp_valid(cmd_rsp_valid), .cmd_rsp_xirr(cmd_rsp_xirr),
    .offer_valid(offer_valid), .offer_num(offer_num), .offer_pri(offer_pri),
    .offer_ready(offer_ready), .offer_rsp_valid(offer_rsp_valid),
    .offer_rsp_ok(offer_rsp_ok), .reject_valid(reject_valid),
    .reject_num(reject_num), .resend_req(resend_req),
    .eoi_valid(eoi_valid), .eoi_num(eoi_num), .irq_out(irq_out)
  );

  typedef struct {
    bit          rsp_v;
    bit [31:0]   xirr;
    bit          rej_v;
    bit [23:0]   rej_num;
    bit          resend;
    bit          eoi_v;
    bit [23:0]   eoi_num;
    bit          orsp_v;
    bit          orsp_ok;
    bit          irq;
    string       tag;
  } exp_t;

  exp_t q[$];

  // reference model state
  bit [7:0]  m_cppr, m_mfrr, m_pend;
  bit [23:0] m_xisr;
  bit        m_nres;

  task automatic model_reset();
    m_cppr = 8'h00; m_mfrr = 8'hFF; m_pend = 8'hFF; m_xisr = '0; m_nres = 1'b0;
  endtask

  task automatic model_down(input bit [7:0] nc, inout exp_t e);
    m_cppr = nc;
    if (m_mfrr < nc && m_mfrr <= m_pend) begin
      m_pend = m_mfrr; m_xisr = 24'd2;
    end
    e.resend = m_nres;
    m_nres = 1'b0;
  endtask

  task automatic issue(input bit cv, input bit [1:0] op, input bit [31:0] data,
                       input bit ov, input bit [23:0] num, input bit [7:0] pri,
                       input string tag);
    exp_t e;
    bit [23:0] disp;
    e = '{default: 0, tag: tag};
    disp = '0;
    @(negedge clk);
    cmd_valid = cv; cmd_op = op; cmd_data = data;
    offer_valid = ov; offer_num = num; offer_pri = pri;
    if (cv) begin
      case (op)
        2'd0: begin
          e.rsp_v = 1'b1; e.xirr = {m_cppr, m_xisr};
          if (m_xisr != 0) begin
            m_cppr = m_pend; m_pend = 8'hFF; m_xisr = '0;
          end
        end
        2'd1: begin
          if (data[7:0] > m_cppr) model_down(data[7:0], e);
          else if (data[7:0] < m_cppr) begin
            m_cppr = data[7:0];
            if (data[7:0] <= m_pend) begin
              disp = m_xisr; m_xisr = '0; m_pend = 8'hFF;
            end
          end
        end
        2'd2: begin
          if (data[7:0] < m_cppr && data[7:0] <= m_pend) begin
            disp = m_xisr; m_pend = data[7:0]; m_xisr = 24'd2;
          end
          if (data[7:0] > m_mfrr) begin
            e.resend = m_nres; m_nres = 1'b0;
          end
          m_mfrr = data[7:0];
        end
        default: begin
          model_down(data[31:24], e);
          if (data[23:0] != 24'd2) begin
            e.eoi_v = 1'b1; e.eoi_num = data[23:0];
          end
        end
      endcase
    end else if (ov) begin
      e.orsp_v = 1'b1;
      if (m_cppr > pri && m_mfrr > pri && m_pend > pri) begin
        e.orsp_ok = 1'b1; disp = m_xisr; m_xisr = num; m_pend = pri;
      end else m_nres = 1'b1;
    end
    if (disp != 0 && disp != 24'd2) begin
      e.rej_v = 1'b1; e.rej_num = disp;
    end
    e.irq = (m_xisr != 0) && (m_pend < m_cppr);
    q.push_back(e);
    if (cv && ov) begin
      #1;
      checks++;
      if (offer_ready !== 1'b0) begin
        errors++;
        $display("FAIL R12: offer_ready actual=%b expected=0", offer_ready);
      end
    end
  endtask

  // monitor: compare one expected item after each edge that follows a push
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        bit bad;
        e = q.pop_front();
        bad = (cmd_rsp_valid !== e.rsp_v) || (e.rsp_v && cmd_rsp_xirr !== e.xirr) ||
              (reject_valid !== e.rej_v) || (e.rej_v && reject_num !== e.rej_num) ||
              (resend_req !== e.resend) || (eoi_valid !== e.eoi_v) ||
              (e.eoi_v && eoi_num !== e.eoi_num) || (offer_rsp_valid !== e.orsp_v) ||
              (offer_rsp_ok !== e.orsp_ok) || (irq_out !== e.irq);
        checks++;
        if (bad) begin
          errors++;
          $display("FAIL %s: actual rsp=%b/%h rej=%b/%h rs=%b eoi=%b/%h off=%b/%b irq=%b expected rsp=%b/%h rej=%b/%h rs=%b eoi=%b/%h off=%b/%b irq=%b",
            e.tag, cmd_rsp_valid, cmd_rsp_xirr, reject_valid, reject_num, resend_req,
            eoi_valid, eoi_num, offer_rsp_valid, offer_rsp_ok, irq_out,
            e.rsp_v, e.xirr, e.rej_v, e.rej_num, e.resend, e.eoi_v, e.eoi_num,
            e.orsp_v, e.orsp_ok, e.irq);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    checks++;
    if (irq_out !== 1'b0 || reject_valid !== 1'b0 || resend_req !== 1'b0) begin
      errors++;
      $display("FAIL R1: actual irq=%b rej=%b rs=%b expected 0 0 0", irq_out, reject_valid, resend_req);
    end
    issue(1, 2'd0, 32'h0, 0, 0, 0, "R1 accept at reset");
    issue(0, 0, 0, 1, 24'h10, 8'd5, "R4 offer blocked by threshold 0");
    issue(1, 2'd1, 32'hFF, 0, 0, 0, "R9 threshold raise drains resend");
    issue(0, 0, 0, 1, 24'h10, 8'd5, "R2 R3 offer accepted");
    issue(0, 0, 0, 1, 24'h20, 8'd3, "R3 better offer displaces 0x10");
    issue(0, 0, 0, 1, 24'h30, 8'd3, "R3 R4 equal priority refused");
    issue(1, 2'd0, 32'h0, 0, 0, 0, "R5 accept pending 0x20");
    issue(1, 2'd2, 32'h1, 0, 0, 0, "R6 request injects IPI");
    issue(1, 2'd2, 32'h4, 0, 0, 0, "R7 request raised emits resend");
    issue(1, 2'd1, 32'h1, 0, 0, 0, "R8 R11 threshold lowered drops IPI");
    issue(1, 2'd1, 32'h1, 0, 0, 0, "R8 equal threshold no effect");
    issue(1, 2'd3, 32'hFF000002, 0, 0, 0, "R10 eoi of IPI not forwarded");
    issue(0, 0, 0, 1, 24'h40, 8'd2, "R11 offer displaces IPI silently");
    issue(1, 2'd0, 32'h0, 0, 0, 0, "R5 accept pending 0x40");
    issue(1, 2'd3, 32'h06000040, 0, 0, 0, "R10 eoi forwarded");
    issue(1, 2'd0, 32'h0, 1, 24'h50, 8'd1, "R12 command wins over offer");
    issue(0, 0, 0, 1, 24'h50, 8'd1, "R12 held offer served");
    issue(1, 2'd2, 32'h0, 0, 0, 0, "R6 request displaces 0x50");
    @(negedge clk);
    cmd_valid = 1'b0; offer_valid = 1'b0;
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule